// File: doc/BRIEF.md
# Buck Power-Stage Gate-Drive Sequencer

This block sequences the two switch gates of a synchronous buck power stage: the high-side and the low-side switch. It takes a PWM command that an analog front end has already sliced into high, low and mid-level flags. It also takes a three-level mode selection that has been sliced into high, low and floating flags. From these it produces two registered gate-enable outputs.

A gate is turned on only after the opposite gate reports that it has dropped below its threshold. For the high side, the switch node must also report that it is low. Feedback that never arrives is covered by a bounded wait, so the sequence cannot stall.

With the mode pin high, the stage runs in forced continuous conduction. With the mode pin low, the low side emulates a diode. After a guaranteed minimum on-time, it is switched off by a reverse-current (zero-cross) indication, and it stays off until the next high-then-low PWM cycle. A PWM level held in the mid band for long enough turns both gates off. A floating mode pin or a missing supply also turns both gates off.

Top module: `buck_gate_seq`

## Requirements
- R1: In continuous mode (`modeHi`=1, `modeLo`=0, `modeFloat`=0), a steady high PWM command (`pwmHi`=1, `pwmLo`=0, `pwmMid`=0) ends with `hsEn`=1 and `lsEn`=0.
- R2: In continuous mode, a steady low PWM command (`pwmHi`=0, `pwmLo`=1, `pwmMid`=0) ends with `lsEn`=1 and `hsEn`=0.
- R3: In emulation mode (`modeLo`=1, `modeHi`=0, `modeFloat`=0), a synchronized `zeroCross` pulse during a low command turns `lsEn` off once the minimum on-time has elapsed. `lsEn` stays off until the command goes high and then low again.
- R4: In emulation mode, a `zeroCross` pulse that arrives before the low side has been on for `MIN_ON` cycles leaves `lsEn` on.
- R5: The PWM command counts as mid-level when `pwmMid`=1 or when `pwmHi` equals `pwmLo`. Both gates turn off only after `TRI_ENTRY` consecutive mid-level cycles. Shorter mid-level episodes leave the gates unchanged.
- R6: Leaving the mid level takes effect only after `TRI_EXIT` consecutive valid cycles. Until then, both gates stay off.
- R7: A floating mode input (`modeFloat`=1), or `modeHi` equal to `modeLo`, forces both gates off from the next cycle on, whatever the PWM command is.
- R8: `supplyOk`=0 forces both gates off from the next cycle on, and they stay off until supply returns.
- R9: `hsEn` and `lsEn` are never 1 together. Each turns on only from a cycle in which the other was off, and only after the synchronized feedback allows it (the other gate is low, and for the high side the switch node is also low) or the wait expires.
- R10: If gate feedback never arrives, the waiting gate turns on after at most `DEAD_TMO`+1 cycles in the dead-time state.
- R11: After reset, both gate enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmHi | input | 1 | PWM above the upper threshold |
| pwmLo | input | 1 | PWM below the lower threshold |
| pwmMid | input | 1 | PWM inside the mid (tri-state) window |
| modeHi | input | 1 | Mode input high: continuous conduction |
| modeLo | input | 1 | Mode input low: diode emulation |
| modeFloat | input | 1 | Mode input floating: shutdown |
| supplyOk | input | 1 | Driver supply above lockout level |
| hsGateLow | input | 1 | High-side gate below threshold (asynchronous) |
| lsGateLow | input | 1 | Low-side gate below threshold (asynchronous) |
| swNodeLow | input | 1 | Switch node has fallen (asynchronous) |
| zeroCross | input | 1 | Reverse-current indication (asynchronous) |
| hsEn | output | 1 | High-side gate enable, registered |
| lsEn | output | 1 | Low-side gate enable, registered |

## Verification
Every cycle, the assertions check the properties that do not depend on history. The two enables are never on together. Each enable rises only from a cycle in which the other was off. Lockout or a floating mode clears both enables one cycle later. Some behaviours depend on counted windows or on order over many cycles, and only the bench scenarios can show them. These are the mid-level hold-off and exit delay, the minimum on-time that masks an early zero-cross, the emulation latch that releases only on a new high-then-low command, and the forced progress when feedback is stuck. A cycle-accurate reference model in the bench covers all of them.

// File: rtl/gsq_pkg.sv
package gsq_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_HS_ON    = 3'd1,
    ST_DEAD_LS  = 3'd2,
    ST_LS_ON    = 3'd3,
    ST_LS_EMOFF = 3'd4,
    ST_DEAD_HS  = 3'd5
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic deadClr;
    logic minOnClr;
  } ctlStrobe_t;

  // conditioned status from datapath to control
  typedef struct packed {
    logic lvlHigh;
    logic triActive;
    logic hsBelow;
    logic lsBelow;
    logic swLow;
    logic zeroX;
    logic deadExpired;
    logic minOnDone;
  } fbStatus_t;

endpackage

// File: rtl/gsq_sync.sv
module gsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shiftQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shiftQ <= '0;
        else       shiftQ <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shiftQ <= '0;
        else       shiftQ <= {shiftQ[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = shiftQ[STAGES-1];
endmodule

// File: rtl/gsq_datapath.sv
module gsq_datapath
  import gsq_pkg::*;
#(
  parameter int TRI_ENTRY   = 35,
  parameter int TRI_EXIT    = 7,
  parameter int MIN_ON      = 120,
  parameter int DEAD_TMO    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmHi,
  input  logic       pwmLo,
  input  logic       pwmMid,
  input  logic       hsGateLow,
  input  logic       lsGateLow,
  input  logic       swNodeLow,
  input  logic       zeroCross,
  input  ctlStrobe_t strb,
  output fbStatus_t  st
);
  localparam int NFLAG = 4;
  localparam int TMAX  = (TRI_ENTRY > TRI_EXIT) ? TRI_ENTRY : TRI_EXIT;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int DW    = $clog2(DEAD_TMO + 1);
  localparam int MW    = $clog2(MIN_ON + 1);
  localparam logic [TW-1:0] ENTRY_LAST = TW'(TRI_ENTRY - 1);
  localparam logic [TW-1:0] EXIT_LAST  = TW'(TRI_EXIT - 1);
  localparam logic [DW-1:0] DEAD_LIM   = DW'(DEAD_TMO);
  localparam logic [MW-1:0] MIN_LIM    = MW'(MIN_ON);

  // asynchronous feedback flags through synchronizers
  logic [NFLAG-1:0] rawFlags;
  logic [NFLAG-1:0] syncFlags;
  assign rawFlags = {zeroCross, swNodeLow, lsGateLow, hsGateLow};

  for (genvar i = 0; i < NFLAG; i++) begin : g_sync
    gsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .d    (rawFlags[i]),
      .q    (syncFlags[i])
    );
  end

  // mid-level hold-off filter and held command level
  logic          rawTri;
  logic          triEff;
  logic          lvl;
  logic [TW-1:0] triCnt;
  logic [TW-1:0] triLast;

  assign rawTri  = pwmMid | (pwmHi ~^ pwmLo);
  assign triLast = triEff ? EXIT_LAST : ENTRY_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      triEff <= 1'b0;
      triCnt <= '0;
    end else if (rawTri != triEff) begin
      if (triCnt == triLast) begin
        triEff <= rawTri;
        triCnt <= '0;
      end else begin
        triCnt <= triCnt + 1'b1;
      end
    end else begin
      triCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lvl <= 1'b0;
    else if (!rawTri) lvl <= pwmHi;
  end

  // dead-time wait limit
  logic [DW-1:0] deadCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    deadCnt <= '0;
    else if (strb.deadClr)        deadCnt <= '0;
    else if (deadCnt != DEAD_LIM) deadCnt <= deadCnt + 1'b1;
  end

  // low-side minimum on-time
  logic [MW-1:0] minCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  minCnt <= '0;
    else if (strb.minOnClr)     minCnt <= '0;
    else if (minCnt != MIN_LIM) minCnt <= minCnt + 1'b1;
  end

  always_comb begin
    st.lvlHigh     = lvl;
    st.triActive   = triEff;
    st.hsBelow     = syncFlags[0];
    st.lsBelow     = syncFlags[1];
    st.swLow       = syncFlags[2];
    st.zeroX       = syncFlags[3];
    st.deadExpired = (deadCnt == DEAD_LIM);
    st.minOnDone   = (minCnt == MIN_LIM);
  end
endmodule

// File: rtl/gsq_control.sv
module gsq_control
  import gsq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       modeHi,
  input  logic       modeLo,
  input  logic       modeFloat,
  input  fbStatus_t  st,
  output ctlStrobe_t strb,
  output logic       hsEn,
  output logic       lsEn
);
  seqState_t state;
  seqState_t nxt;
  logic      shutDown;
  logic      emulMode;

  assign shutDown = ~supplyOk | modeFloat | (modeHi ~^ modeLo);
  assign emulMode = modeLo & ~modeHi;

  always_comb begin
    nxt = state;
    if (shutDown || st.triActive) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:      nxt = st.lvlHigh ? ST_DEAD_HS : ST_DEAD_LS;
        ST_HS_ON:    if (!st.lvlHigh) nxt = ST_DEAD_LS;
        ST_DEAD_LS: begin
          if (st.lvlHigh)                         nxt = ST_DEAD_HS;
          else if (st.hsBelow || st.deadExpired)  nxt = ST_LS_ON;
        end
        ST_LS_ON: begin
          if (st.lvlHigh)                                   nxt = ST_DEAD_HS;
          else if (emulMode && st.minOnDone && st.zeroX)    nxt = ST_LS_EMOFF;
        end
        ST_LS_EMOFF: if (st.lvlHigh) nxt = ST_DEAD_HS;
        ST_DEAD_HS: begin
          if (!st.lvlHigh)                                     nxt = ST_DEAD_LS;
          else if ((st.lsBelow && st.swLow) || st.deadExpired) nxt = ST_HS_ON;
        end
        default:     nxt = ST_OFF;
      endcase
    end
  end

  always_comb begin
    strb.deadClr  = ((nxt == ST_DEAD_LS) || (nxt == ST_DEAD_HS)) && (nxt != state);
    strb.minOnClr = (nxt == ST_LS_ON) && (state != ST_LS_ON);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_OFF;
      hsEn  <= 1'b0;
      lsEn  <= 1'b0;
    end else begin
      state <= nxt;
      hsEn  <= (nxt == ST_HS_ON);
      lsEn  <= (nxt == ST_LS_ON);
    end
  end
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import gsq_pkg::*;
#(
  parameter int TRI_ENTRY   = 35,
  parameter int TRI_EXIT    = 7,
  parameter int MIN_ON      = 120,
  parameter int DEAD_TMO    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmHi,
  input  logic pwmLo,
  input  logic pwmMid,
  input  logic modeHi,
  input  logic modeLo,
  input  logic modeFloat,
  input  logic supplyOk,
  input  logic hsGateLow,
  input  logic lsGateLow,
  input  logic swNodeLow,
  input  logic zeroCross,
  output logic hsEn,
  output logic lsEn
);
  ctlStrobe_t strb;
  fbStatus_t  st;

  gsq_datapath #(
    .TRI_ENTRY   (TRI_ENTRY),
    .TRI_EXIT    (TRI_EXIT),
    .MIN_ON      (MIN_ON),
    .DEAD_TMO    (DEAD_TMO),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pwmHi     (pwmHi),
    .pwmLo     (pwmLo),
    .pwmMid    (pwmMid),
    .hsGateLow (hsGateLow),
    .lsGateLow (lsGateLow),
    .swNodeLow (swNodeLow),
    .zeroCross (zeroCross),
    .strb      (strb),
    .st        (st)
  );

  gsq_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .supplyOk  (supplyOk),
    .modeHi    (modeHi),
    .modeLo    (modeLo),
    .modeFloat (modeFloat),
    .st        (st),
    .strb      (strb),
    .hsEn      (hsEn),
    .lsEn      (lsEn)
  );
endmodule

// File: rtl/buck_gate_seq_chk.sv
module buck_gate_seq_chk (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic modeFloat,
  input logic hsEn,
  input logic lsEn
);
  // R9: the enables never overlap
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(hsEn && lsEn));

  // R9: high side rises only from a cycle with the low side off
  p_hs_after_ls_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsEn) |-> !$past(lsEn));

  // R9: low side rises only from a cycle with the high side off
  p_ls_after_hs_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsEn) |-> !$past(hsEn));

  // R8: lockout clears both enables
  p_lockout_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (!hsEn && !lsEn));

  // R7: floating mode shuts the stage down
  p_float_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    modeFloat |=> (!hsEn && !lsEn));
endmodule

bind buck_gate_seq buck_gate_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .supplyOk  (supplyOk),
  .modeFloat (modeFloat),
  .hsEn      (hsEn),
  .lsEn      (lsEn)
);

// File: tb/sim_buck_gate_seq.sv
module sim_buck_gate_seq;
  localparam int ENTRY = 35;
  localparam int EXITN = 7;
  localparam int MINON = 120;
  localparam int TMO   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmHi = 1'b0, pwmLo = 1'b1, pwmMid = 1'b0;
  logic modeHi = 1'b1, modeLo = 1'b0, modeFloat = 1'b0;
  logic supplyOk = 1'b1;
  logic hsGateLow = 1'b1, lsGateLow = 1'b1, swNodeLow = 1'b1, zeroCross = 1'b0;
  logic hsEn, lsEn;
  logic stuckLs = 1'b0;

  int tests = 0, fails = 0;
  bit done = 0, cmpOn = 0;
  string curReq = "R11";

  always #4 clk = ~clk;

  buck_gate_seq u0 (
    .clk(clk), .rstN(rstN), .pwmHi(pwmHi), .pwmLo(pwmLo), .pwmMid(pwmMid),
    .modeHi(modeHi), .modeLo(modeLo), .modeFloat(modeFloat), .supplyOk(supplyOk),
    .hsGateLow(hsGateLow), .lsGateLow(lsGateLow), .swNodeLow(swNodeLow),
    .zeroCross(zeroCross), .hsEn(hsEn), .lsEn(lsEn)
  );

  // simple power-stage model: a gate reads low three samples after its enable drops
  logic [2:0] hsHist = '0, lsHist = '0;
  always @(negedge clk) begin
    hsHist    <= {hsHist[1:0], hsEn};
    lsHist    <= {lsHist[1:0], lsEn};
    hsGateLow <= ~|{hsHist[1:0], hsEn};
    swNodeLow <= ~|{hsHist[1:0], hsEn};
    lsGateLow <= stuckLs ? 1'b0 : ~|{lsHist[1:0], lsEn};
  end

  // behavioural reference: 0 off,1 high on,2 wait-for-low,3 low on,4 emulated off,5 wait-for-high
  int  mState = 0, mTriCnt = 0, mDead = 0, mMin = 0;
  bit  mTri = 0, mLvl = 0, mHs = 0, mLs = 0;
  bit  fHs[2], fLs[2], fSw[2], fZc[2];
  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mTriCnt = 0; mDead = 0; mMin = 0; mTri = 0; mLvl = 0;
      mHs = 0; mLs = 0;
      for (int k = 0; k < 2; k++) begin fHs[k] = 0; fLs[k] = 0; fSw[k] = 0; fZc[k] = 0; end
    end else begin
      bit rawTri, shut, dem;
      int ns;
      rawTri = pwmMid || (pwmHi == pwmLo);
      shut   = !supplyOk || modeFloat || (modeHi == modeLo);
      dem    = modeLo && !modeHi;
      ns = mState;
      if (shut || mTri) ns = 0;
      else case (mState)
        0: ns = mLvl ? 5 : 2;
        1: if (!mLvl) ns = 2;
        2: if (mLvl) ns = 5; else if (fHs[1] || mDead >= TMO) ns = 3;
        3: if (mLvl) ns = 5; else if (dem && mMin >= MINON && fZc[1]) ns = 4;
        4: if (mLvl) ns = 5;
        5: if (!mLvl) ns = 2; else if ((fLs[1] && fSw[1]) || mDead >= TMO) ns = 1;
        default: ns = 0;
      endcase
      if ((ns == 2 || ns == 5) && ns != mState) mDead = 0;
      else if (mDead < TMO) mDead++;
      if (ns == 3 && mState != 3) mMin = 0;
      else if (mMin < MINON) mMin++;
      if (rawTri != mTri) begin
        if (mTriCnt == (mTri ? EXITN : ENTRY) - 1) begin mTri = rawTri; mTriCnt = 0; end
        else mTriCnt++;
      end else mTriCnt = 0;
      if (!rawTri) mLvl = pwmHi;
      fHs[1] = fHs[0]; fHs[0] = hsGateLow;
      fLs[1] = fLs[0]; fLs[0] = lsGateLow;
      fSw[1] = fSw[0]; fSw[0] = swNodeLow;
      fZc[1] = fZc[0]; fZc[0] = zeroCross;
      mState = ns; mHs = (ns == 1); mLs = (ns == 3);
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmpOn) begin
      tests++;
      if (hsEn !== mHs || lsEn !== mLs) begin
        fails++;
        $display("FAIL %s per-cycle: hs=%0b ls=%0b expected hs=%0b ls=%0b at %0t",
                 curReq, hsEn, lsEn, mHs, mLs, $time);
      end
    end
  end

  task automatic chk(input bit expHs, input bit expLs, input string tag);
    tests++;
    if (hsEn !== expHs || lsEn !== expLs) begin
      fails++;
      $display("FAIL %s: hs=%0b ls=%0b expected hs=%0b ls=%0b", tag, hsEn, lsEn, expHs, expLs);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 low, 1 high, 2 mid-level
  task automatic setPwm(input int v);
    pwmHi = (v == 1); pwmLo = (v == 0); pwmMid = (v == 2);
  endtask

  task automatic zcPulse();
    zeroCross = 1'b1; wait_n(1); zeroCross = 1'b0;
  endtask

  initial begin
    wait_n(3);
    chk(0, 0, "R11 reset");
    rstN = 1'b1; cmpOn = 1;
    wait_n(1);
    chk(0, 0, "R11 after release");

    curReq = "R2"; setPwm(0); wait_n(40); chk(0, 1, "R2 ccm low");
    curReq = "R1"; setPwm(1); wait_n(40); chk(1, 0, "R1 ccm high");
    curReq = "R2"; setPwm(0); wait_n(40); chk(0, 1, "R2 ccm low again");

    // emulation mode
    curReq = "R4"; modeHi = 0; modeLo = 1;
    setPwm(1); wait_n(40); chk(1, 0, "R1 emulation high");
    setPwm(0); wait_n(30); chk(0, 1, "R4 low side on");
    zcPulse(); wait_n(10); chk(0, 1, "R4 early zero-cross ignored");
    curReq = "R3"; wait_n(170); chk(0, 1, "R3 still on before zero-cross");
    zcPulse(); wait_n(10); chk(0, 0, "R3 zero-cross turns low side off");
    wait_n(30); chk(0, 0, "R3 stays off while low");
    setPwm(1); wait_n(40); chk(1, 0, "R3 high after emulated off");
    setPwm(0); wait_n(40); chk(0, 1, "R3 re-armed by new cycle");

    // mid-level filter
    curReq = "R5"; modeHi = 1; modeLo = 0;
    setPwm(2); wait_n(15); chk(0, 1, "R5 glitch not yet effective");
    wait_n(5); setPwm(0); wait_n(10); chk(0, 1, "R5 short mid-level ignored");
    setPwm(2); wait_n(50); chk(0, 0, "R5 sustained mid-level off");
    curReq = "R6"; setPwm(1); wait_n(3); chk(0, 0, "R6 exit delay holds off");
    wait_n(40); chk(1, 0, "R6 resumes after exit");

    // floating mode
    curReq = "R7"; modeFloat = 1; wait_n(3); chk(0, 0, "R7 float shutdown");
    setPwm(0); wait_n(20); chk(0, 0, "R7 ignores pwm");
    modeFloat = 0; modeHi = 1; modeLo = 1; wait_n(10); chk(0, 0, "R7 both mode flags");
    modeLo = 0; wait_n(40); chk(0, 1, "R7 recovers");

    // lockout
    curReq = "R8"; supplyOk = 0; wait_n(3); chk(0, 0, "R8 lockout");
    setPwm(1); wait_n(20); chk(0, 0, "R8 held off");
    supplyOk = 1; wait_n(40); chk(1, 0, "R8 recovers");

    // stuck feedback timeout
    curReq = "R10"; setPwm(0); wait_n(40); chk(0, 1, "R10 setup");
    stuckLs = 1; setPwm(1); wait_n(8); chk(0, 0, "R9 waits for feedback");
    wait_n(30); chk(1, 0, "R10 timeout forces high side");
    stuckLs = 0; setPwm(0); wait_n(40); chk(0, 1, "R10 normal after");

    curReq = "R9"; wait_n(5);
    cmpOn = 0; done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule